// File: doc/BRIEF.md
# Power-Good Sequencer

This block turns a digital "supply above threshold" comparator result into a power-good flag. The flag rises only after the comparator has held high for a set number of timing ticks. It falls after only a short deglitch run of low samples. A free-running tick input paces both intervals, so one clock domain serves any delay range. The assertion delay is either a programmed count or a fixed default count, chosen by a select input.

The block also drives a regulator-on flag. This flag follows enable, undervoltage lockout and thermal shutdown, and it changes in the same cycle as those inputs. While the regulator is off, power-good is forced low and all timing is cleared. When the regulator returns, the full power-up delay runs again. The block emits single-cycle pulses on each rising and each falling edge of power-good, for downstream reset and sequencing logic.

Top module: `pg_sequencer`

## Requirements
- R1: While rst_ni is low, pg_o, pg_rise_o and pg_fall_o are 0.
- R2: reg_on_o is high exactly when en_i is high, uvlo_i is low and tsd_i is low. It follows these inputs combinationally, in the same cycle.
- R3: After reg_on_o rises, the first clock cycle is a start-up cycle. From the second cycle on, each clock edge with tick_i and cmp_above_i both high counts once. pg_o goes high at the edge of the N-th counted tick, where N is delay_i when use_default_i is low, and a delay_i of 0 counts as 1.
- R4: When use_default_i is high, N is the parameter DEF_DLY (default 12) and delay_i is ignored.
- R5: While the delay is running, any clock edge with cmp_above_i low clears the count, so N further counted ticks are needed.
- R6: While pg_o is high, it drops at the edge of the 4th consecutive tick sampled with cmp_above_i low. A tick sampled with cmp_above_i high resets this run. Cycles without a tick do not affect the run.
- R7: If reg_on_o is low at a clock edge, pg_o is low after that edge. When reg_on_o returns high, the full R3 sequence must run again, whether the cause was enable, undervoltage or thermal shutdown.
- R8: pg_rise_o is high for exactly the first cycle in which pg_o is high. pg_fall_o is high for exactly the first cycle in which pg_o is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timing tick |
| en_i | input | 1 | Regulator enable |
| uvlo_i | input | 1 | Undervoltage lockout flag |
| tsd_i | input | 1 | Thermal shutdown flag |
| cmp_above_i | input | 1 | Comparator: 1 = above threshold, 0 = below threshold minus hysteresis |
| use_default_i | input | 1 | 1 selects the default delay DEF_DLY |
| delay_i | input | DLY_W | Programmed delay in ticks |
| reg_on_o | output | 1 | Regulator active |
| pg_o | output | 1 | Power-good flag |
| pg_rise_o | output | 1 | Pulse in the first cycle pg_o is high |
| pg_fall_o | output | 1 | Pulse in the first cycle pg_o is low again |

## Verification
The hardest case to reach is a deglitch run that is broken and then restarted. From outside, the only sign of the internal count is whether pg_o drops. The stimulus first raises power-good. It then applies three low ticks, one high tick and three more low ticks, and confirms that pg_o is still high. A fourth low tick must then lower it, with a fall pulse. Delay restarts are tested the same way: a low comparator cycle is inserted in the middle of the delay, and the bench checks that only a full new count raises power-good. Undervoltage recovery is likewise checked to need the full count again.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_GOOD = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pg_supply_gate.sv
module pg_supply_gate (
  input  logic en_i,
  input  logic uvlo_i,
  input  logic tsd_i,
  output logic reg_on_o
);
  always_comb reg_on_o = en_i && !uvlo_i && !tsd_i;
endmodule

// File: rtl/pg_delay_timer.sv
module pg_delay_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [DLY_W-1:0] limit_i,
  output logic             done_o
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W:0]   limit_eff;
  logic [DLY_W:0]   cnt_nxt;

  always_comb begin
    limit_eff = (limit_i == '0) ? (DLY_W+1)'(1) : {1'b0, limit_i};
    cnt_nxt   = {1'b0, cnt_q} + (DLY_W+1)'(1);
    done_o    = !clr_i && step_i && (cnt_nxt >= limit_eff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || done_o)    cnt_q <= '0;
    else if (step_i)             cnt_q <= cnt_nxt[DLY_W-1:0];
  end

  // R5: a clear always empties the count
  a_r5_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pg_deglitch.sv
module pg_deglitch #(
  parameter int DG_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic above_i,
  output logic trip_o
);
  localparam int DG_W = $clog2(DG_TICKS + 1);
  logic [DG_W-1:0] cnt_q;

  always_comb trip_o = !clr_i && tick_i && !above_i && (cnt_q == DG_W'(DG_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || trip_o)   cnt_q <= '0;
    else if (tick_i) begin
      if (above_i) cnt_q <= '0;
      else         cnt_q <= cnt_q + DG_W'(1);
    end
  end

  a_r6_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < DG_W'(DG_TICKS));
  a_r6_high_tick_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && above_i) |=> (cnt_q == '0));
endmodule

// File: rtl/pg_sequencer.sv
module pg_sequencer #(
  parameter int DLY_W    = 8,
  parameter int DEF_DLY  = 12,
  parameter int DG_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             uvlo_i,
  input  logic             tsd_i,
  input  logic             cmp_above_i,
  input  logic             use_default_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             reg_on_o,
  output logic             pg_o,
  output logic             pg_rise_o,
  output logic             pg_fall_o
);
  import pg_pkg::*;

  pg_state_e        state_q, state_d;
  logic             dly_done, dg_trip;
  logic [DLY_W-1:0] dly_limit;
  logic             rise_q, fall_q;
  logic             pg_next;

  pg_supply_gate u_gate (
    .en_i    (en_i),
    .uvlo_i  (uvlo_i),
    .tsd_i   (tsd_i),
    .reg_on_o(reg_on_o)
  );

  always_comb dly_limit = use_default_i ? DLY_W'(DEF_DLY) : delay_i;

  pg_delay_timer #(.DLY_W(DLY_W)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!reg_on_o || (state_q != ST_WAIT) || !cmp_above_i),
    .step_i (tick_i && cmp_above_i),
    .limit_i(dly_limit),
    .done_o (dly_done)
  );

  pg_deglitch #(.DG_TICKS(DG_TICKS)) u_dg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!reg_on_o || (state_q != ST_GOOD)),
    .tick_i (tick_i),
    .above_i(cmp_above_i),
    .trip_o (dg_trip)
  );

  always_comb begin
    state_d = state_q;
    if (!reg_on_o) state_d = ST_OFF;
    else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_WAIT;
        ST_WAIT: if (dly_done) state_d = ST_GOOD;
        ST_GOOD: if (dg_trip)  state_d = ST_WAIT;
        default: state_d = ST_OFF;
      endcase
    end
    pg_next = (state_d == ST_GOOD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rise_q  <= pg_next && (state_q != ST_GOOD);
      fall_q  <= !pg_next && (state_q == ST_GOOD);
    end
  end

  assign pg_o      = (state_q == ST_GOOD);
  assign pg_rise_o = rise_q;
  assign pg_fall_o = fall_q;

  a_r7_off_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_on_o |=> !pg_o);
  a_r3_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_rise_o |-> $past(tick_i && cmp_above_i && reg_on_o));
  a_r8_rise_is_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_rise_o |-> (pg_o && !$past(pg_o)));
  a_r6_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_fall_o |-> (!pg_o && (!$past(reg_on_o) || $past(tick_i && !cmp_above_i))));
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pg_rise_o, pg_fall_o}));
endmodule

// File: tb/pg_sequencer_test.sv
module pg_sequencer_test;
  localparam int DLY_W   = 8;
  localparam int DEF_DLY = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, en_i = 1'b0, uvlo_i = 1'b0, tsd_i = 1'b0;
  logic cmp_above_i = 1'b0, use_default_i = 1'b0;
  logic [DLY_W-1:0] delay_i = '0;
  logic reg_on_o, pg_o, pg_rise_o, pg_fall_o;

  int total = 0, failed = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pg_sequencer #(.DLY_W(DLY_W), .DEF_DLY(DEF_DLY)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i),
    .uvlo_i(uvlo_i), .tsd_i(tsd_i), .cmp_above_i(cmp_above_i),
    .use_default_i(use_default_i), .delay_i(delay_i),
    .reg_on_o(reg_on_o), .pg_o(pg_o), .pg_rise_o(pg_rise_o), .pg_fall_o(pg_fall_o)
  );

  // {delay, use_default, expected tick count}
  typedef struct packed { logic [7:0] dly; logic dflt; logic [7:0] n; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'd5,   1'b0, 8'd5},
    '{8'd1,   1'b0, 8'd1},
    '{8'd0,   1'b0, 8'd1},
    '{8'd3,   1'b1, 8'(DEF_DLY)},
    '{8'd40,  1'b0, 8'd40},
    '{8'd255, 1'b1, 8'(DEF_DLY)}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick(logic above);
    cmp_above_i = above; tick_i = 1'b1;
    step();
    tick_i = 1'b0;
  endtask

  task automatic restart();
    en_i = 1'b0; step();
    en_i = 1'b1; step();
  endtask

  task automatic reach_good(int n);
    restart();
    for (int i = 0; i < n; i++) tick(1'b1);
  endtask

  initial begin
    // R1
    #1;
    chk("R1 pg", pg_o, 0);
    chk("R1 rise", pg_rise_o, 0);
    chk("R1 fall", pg_fall_o, 0);
    step(); step();
    rst_ni = 1'b1;
    step();

    // R2
    en_i = 1'b1; #1;
    chk("R2 on", reg_on_o, 1);
    uvlo_i = 1'b1; #1;
    chk("R2 uvlo", reg_on_o, 0);
    uvlo_i = 1'b0; tsd_i = 1'b1; #1;
    chk("R2 tsd", reg_on_o, 0);
    tsd_i = 1'b0; en_i = 1'b0; #1;
    chk("R2 en", reg_on_o, 0);

    // R3/R4 table
    for (int v = 0; v < 6; v++) begin
      delay_i = VECS[v].dly; use_default_i = VECS[v].dflt;
      restart();
      for (int i = 0; i < int'(VECS[v].n) - 1; i++) tick(1'b1);
      chk(VECS[v].dflt ? "R4 before" : "R3 before", pg_o, 0);
      tick(1'b1);
      chk(VECS[v].dflt ? "R4 after" : "R3 after", pg_o, 1);
      chk("R8 rise", pg_rise_o, 1);
      step();
      chk("R8 rise once", pg_rise_o, 0);
    end

    // R3 start-up cycle: tick in first cycle after enable is not counted
    use_default_i = 1'b0; delay_i = 8'd2;
    en_i = 1'b0; step();
    en_i = 1'b1; tick(1'b1); tick(1'b1);
    chk("R3 startup skip", pg_o, 0);
    tick(1'b1);
    chk("R3 startup done", pg_o, 1);

    // R5 restart on comparator low
    delay_i = 8'd5;
    restart();
    tick(1'b1); tick(1'b1); tick(1'b1);
    cmp_above_i = 1'b0; step(); cmp_above_i = 1'b1;
    for (int i = 0; i < 4; i++) tick(1'b1);
    chk("R5 restarted", pg_o, 0);
    tick(1'b1);
    chk("R5 full count", pg_o, 1);

    // R6 deglitch
    tick(1'b0); tick(1'b0); tick(1'b0);
    tick(1'b1);
    tick(1'b0); tick(1'b0); tick(1'b0);
    cmp_above_i = 1'b0; step(); step();
    chk("R6 broken run", pg_o, 1);
    tick(1'b0);
    chk("R6 drop", pg_o, 0);
    chk("R8 fall", pg_fall_o, 1);
    step();
    chk("R8 fall once", pg_fall_o, 0);

    // R7 undervoltage restart
    delay_i = 8'd3; cmp_above_i = 1'b1;
    reach_good(3);
    chk("R7 good", pg_o, 1);
    uvlo_i = 1'b1; #1;
    chk("R7 uvlo off", reg_on_o, 0);
    step();
    chk("R7 pg low", pg_o, 0);
    chk("R7 fall", pg_fall_o, 1);
    tick(1'b1);
    chk("R7 no count while off", pg_o, 0);
    uvlo_i = 1'b0; step();
    tick(1'b1); tick(1'b1);
    chk("R7 full delay", pg_o, 0);
    tick(1'b1);
    chk("R7 back", pg_o, 1);

    // R7 thermal shutdown
    tsd_i = 1'b1; step();
    chk("R7 tsd low", pg_o, 0);
    tsd_i = 1'b0; step();
    tick(1'b1); tick(1'b1);
    chk("R7 tsd delay", pg_o, 0);
    tick(1'b1);
    chk("R7 tsd back", pg_o, 1);

    finished = 1;
    $display("  %0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule